// File: doc/BRIEF.md
# Phase-code distribution imbalance detector

This block sits behind a 4-bit phase-domain quantizer. Each sample arrives as a word of zero-crossing signs, one bit per rotated projection of the input vector. The block turns the word into a sector index. It then counts, over a window of programmable length, how the accepted samples divide between opposing halves and quadrant pairs of the IQ plane. With no impairment and with phases spread evenly, each count comes out balanced. A DC offset on I or on Q, or unequal I and Q gains, moves samples toward one side. The signed differences at the end of each window therefore give the sign and the relative size of each impairment. No amplitude samples are used.

At the end of each window the three signed imbalances and the number of malformed sign words are latched and a one-cycle result strobe is raised. The next window starts on the following sample with no gap. Each imbalance also carries a flag that is set when its magnitude is above a programmable threshold. A synchronous clear discards a partial window and starts a new one.

Top module: `phase_imbal_det`

## Requirements
- R1: Sign bit j of a valid word for sector k (k = 0..15, sector k spanning k*22.5 to (k+1)*22.5 degrees) is 1 exactly when (k - j) mod 16 is below 8. Sector 0 is 8'h01, sector 7 is 8'hFF, sector 8 is 8'hFE and sector 15 is 8'h00. Each valid word is decoded to its sector.
- R2: A word that matches none of the 16 patterns (for example 8'h05) is a bubble. It adds nothing to any imbalance, still counts toward the window length, and is included in res_bubbles for that window.
- R3: imb_i equals the count of samples in sectors 0-3 and 12-15 (right half) minus the count in sectors 4-11 (left half).
- R4: imb_q equals the count in sectors 0-7 (top half) minus the count in sectors 8-15 (bottom half).
- R5: imb_g equals the count in sectors 0-3 plus 8-11 (first and third quadrants) minus the count in sectors 4-7 plus 12-15.
- R6: A window holds 2^L accepted samples, with L equal to win_sel clamped to the range 8..16. res_valid is high for exactly one cycle, in the cycle after the clock edge that accepts the last sample of the window. The signed outputs hold plus or minus 65536 without wrapping.
- R7: Windows run back to back. The sample that follows the last sample of one window is the first sample of the next window.
- R8: L is captured when a window begins: at reset (where L is 8), on clr, and on the edge that ends a window. A change of win_sel in the middle of a window takes effect only in the next window.
- R9: When clr is high on a clock edge, the partial counts are discarded and any sample offered on that edge is dropped. The next window starts with the following sample. Latched results are kept.
- R10: On the edge that ends a window, flag_i, flag_q and flag_g are set to whether the magnitude of the matching imbalance is strictly greater than thr.
- R11: After reset, res_valid is 0 and every result output is 0.
- R12: When in_valid is low, in_word has no effect on any count or on the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of the window |
| win_sel | input | 5 | Log2 of the window length (clamped to 8..16) |
| thr | input | 17 | Magnitude threshold for the flags |
| in_valid | input | 1 | in_word carries a sample on this cycle |
| in_word | input | 8 | Zero-crossing sign word |
| res_valid | output | 1 | One-cycle strobe marking new results |
| imb_i | output | 18 | Signed right-minus-left imbalance |
| imb_q | output | 18 | Signed top-minus-bottom imbalance |
| imb_g | output | 18 | Signed quadrant-pair imbalance |
| flag_i | output | 1 | Magnitude of imb_i is above thr |
| flag_q | output | 1 | Magnitude of imb_q is above thr |
| flag_g | output | 1 | Magnitude of imb_g is above thr |
| res_bubbles | output | 17 | Count of malformed words in the last window |

## Verification
The bench counts its expected values from an angle-based placement of each sector. It then sends windows that all fall in one sector, windows split between two sectors, windows with bubbles, and windows with idle cycles that carry a bubble pattern. An off-by-one window, a lost sample at the boundary between windows, or bubbles counted as sector 0 or sector 15 would each give counts that miss by at least one. The flag tests put the imbalance exactly at thr and one above it, so a non-strict compare shows up. A 65536-sample window filled with one sector would wrap an accumulator that is one bit too narrow. A win_sel change in the middle of a window and a clr in the middle of a window would each move the result strobe to a cycle the bench does not expect.

// File: rtl/pimb_pkg.sv
package pimb_pkg;

  // Which plane regions a sector sits in: right half, top half, Q1/Q3 pair.
  typedef struct packed {
    logic right;
    logic top;
    logic diag;
  } region_t;

  function automatic region_t regions_of(int sector, int nbits);
    region_t r;
    int quad;
    quad   = sector >> (nbits - 2);
    r.right = (quad == 0) || (quad == 3);
    r.top   = (quad < 2);
    r.diag  = (quad == 0) || (quad == 2);
    return r;
  endfunction

  function automatic int clamp_len(int sel, int lo, int hi);
    if (sel < lo) return lo;
    if (sel > hi) return hi;
    return sel;
  endfunction

endpackage

// File: rtl/pimb_decode.sv
module pimb_decode
  import pimb_pkg::*;
#(
  parameter int NB = 4,
  localparam int W = 1 << (NB - 1),
  localparam int S = 1 << NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  word,
  output logic          ok,
  output logic [NB-1:0] sector,
  output region_t       regs
);

  // Circular thermometer pattern of sector k.
  function automatic logic [W-1:0] pattern_of(int k);
    logic [W-1:0] p;
    for (int j = 0; j < W; j++) begin
      if (k < W) p[j] = (j <= k);
      else       p[j] = (j > k - W);
    end
    return p;
  endfunction

  logic [S-1:0] hit;

  genvar gk;
  generate
    for (gk = 0; gk < S; gk++) begin : g_match
      assign hit[gk] = (word == pattern_of(gk));
    end
  endgenerate

  always_comb begin
    ok     = 1'b0;
    sector = '0;
    for (int k = 0; k < S; k++) begin
      if (hit[k]) begin
        ok     = 1'b1;
        sector = NB'(k);
      end
    end
  end

  assign regs = regions_of(int'(sector), NB);

  // R1: the decoded sector agrees with the number of set sign bits.
  a_r1_sector: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (word[0] ? (int'(sector) == $countones(word) - 1)
                    : (int'(sector) == S - 1 - $countones(word))));

  // R2: a word with set bits that are not contiguous is never accepted.
  a_r2_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (word == W'(5)) |-> !ok);

endmodule

// File: rtl/pimb_window.sv
module pimb_window
  import pimb_pkg::*;
#(
  parameter int MIN_LOG2 = 8,
  parameter int MAX_LOG2 = 16,
  localparam int CW = MAX_LOG2 + 1,
  localparam int SW = $clog2(MAX_LOG2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          bubble,
  input  logic [SW-1:0] win_sel,
  output logic          fin,
  output logic [SW-1:0] len_now,
  output logic [CW-1:0] res_bubbles
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] bub;
  logic [CW-1:0] last;
  logic [CW-1:0] bub_n;
  logic [SW-1:0] len_sel;

  assign last    = (CW'(1) << len_now) - CW'(1);
  assign fin     = take && !clr && (cnt == last);
  assign bub_n   = bub + CW'(bubble && take);
  assign len_sel = SW'(clamp_len(int'(win_sel), MIN_LOG2, MAX_LOG2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      bub         <= '0;
      len_now     <= SW'(MIN_LOG2);
      res_bubbles <= '0;
    end else if (clr) begin
      cnt     <= '0;
      bub     <= '0;
      len_now <= len_sel;
    end else if (fin) begin
      cnt         <= '0;
      bub         <= '0;
      res_bubbles <= bub_n;
      len_now     <= len_sel;
    end else if (take) begin
      cnt <= cnt + CW'(1);
      bub <= bub_n;
    end
  end

  // R6: the sample count never passes the end of the window in use.
  a_r6_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);

  // R6: the length in use always lies inside the allowed range.
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(len_now) >= MIN_LOG2) && (int'(len_now) <= MAX_LOG2));

  // R9: a clear leaves the window empty.
  a_r9_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0) && (bub == '0));

endmodule

// File: rtl/pimb_accum.sv
module pimb_accum #(
  parameter int AW = 18,
  parameter int CW = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic                 up,
  input  logic                 fin,
  input  logic [CW-1:0]        thr,
  output logic signed [AW-1:0] total,
  output logic                 flag
);

  function automatic logic [AW-1:0] mag(logic signed [AW-1:0] v);
    return v[AW-1] ? AW'(-v) : AW'(v);
  endfunction

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] delta;
  logic signed [AW-1:0] acc_n;

  assign delta = step ? (up ? AW'(1) : {AW{1'b1}}) : '0;
  assign acc_n = acc + delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      total <= '0;
      flag  <= 1'b0;
    end else if (clr) begin
      acc <= '0;
    end else if (fin) begin
      total <= acc_n;
      flag  <= (mag(acc_n) > AW'(thr));
      acc   <= '0;
    end else begin
      acc <= acc_n;
    end
  end

  // R3: the running sum moves by at most one count per cycle.
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !fin) |=> (mag(acc - $past(acc)) <= AW'(1)));

endmodule

// File: rtl/phase_imbal_det.sv
module phase_imbal_det
  import pimb_pkg::*;
#(
  parameter int NB       = 4,
  parameter int MIN_LOG2 = 8,
  parameter int MAX_LOG2 = 16,
  localparam int W  = 1 << (NB - 1),
  localparam int CW = MAX_LOG2 + 1,
  localparam int AW = CW + 1,
  localparam int SW = $clog2(MAX_LOG2 + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [SW-1:0]        win_sel,
  input  logic [CW-1:0]        thr,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_word,
  output logic                 res_valid,
  output logic signed [AW-1:0] imb_i,
  output logic signed [AW-1:0] imb_q,
  output logic signed [AW-1:0] imb_g,
  output logic                 flag_i,
  output logic                 flag_q,
  output logic                 flag_g,
  output logic [CW-1:0]        res_bubbles
);

  function automatic int mag_of(logic signed [AW-1:0] v);
    return v[AW-1] ? -int'(v) : int'(v);
  endfunction

  // Named internal events, brought out for the assertions.
  logic          code_ok;
  logic [NB-1:0] code_sector;
  region_t       code_regs;
  logic          win_end;
  logic [SW-1:0] win_len;
  logic          sample_step;

  pimb_decode #(.NB(NB)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .word   (in_word),
    .ok     (code_ok),
    .sector (code_sector),
    .regs   (code_regs)
  );

  pimb_window #(.MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .take        (in_valid),
    .bubble      (!code_ok),
    .win_sel     (win_sel),
    .fin         (win_end),
    .len_now     (win_len),
    .res_bubbles (res_bubbles)
  );

  assign sample_step = in_valid && code_ok && !clr;

  logic [2:0]           dir_up;
  logic signed [AW-1:0] totals [3];
  logic [2:0]           flags;

  assign dir_up = {code_regs.diag, code_regs.top, code_regs.right};

  genvar ga;
  generate
    for (ga = 0; ga < 3; ga++) begin : g_acc
      pimb_accum #(.AW(AW), .CW(CW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (sample_step),
        .up    (dir_up[ga]),
        .fin   (win_end),
        .thr   (thr),
        .total (totals[ga]),
        .flag  (flags[ga])
      );
    end
  endgenerate

  assign imb_i  = totals[0];
  assign imb_q  = totals[1];
  assign imb_g  = totals[2];
  assign flag_i = flags[0];
  assign flag_q = flags[1];
  assign flag_g = flags[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= win_end;
  end

  // R6: the result strobe lasts one cycle.
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R3: all three imbalances come from the same number of good samples, so they share parity.
  a_r3_parity: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((imb_i[0] == imb_q[0]) && (imb_q[0] == imb_g[0])));

  // R2: good samples plus bubbles never exceed the length of the window just closed.
  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (mag_of(imb_i) + int'(res_bubbles) <= (1 << $past(win_len))));

  // R10: a flag is set only if its imbalance is nonzero.
  a_r10_flag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_g |-> (imb_g != '0));

endmodule

// File: tb/sim_phase_imbal_det.sv
`timescale 1ns/100ps
module sim_phase_imbal_det;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [4:0]  win_sel = 5'd8;
  logic [16:0] thr = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_word = 8'h00;
  logic        res_valid;
  logic signed [17:0] imb_i, imb_q, imb_g;
  logic        flag_i, flag_q, flag_g;
  logic [16:0] res_bubbles;

  always #2.5 clk = ~clk;

  phase_imbal_det u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .win_sel(win_sel), .thr(thr),
    .in_valid(in_valid), .in_word(in_word), .res_valid(res_valid),
    .imb_i(imb_i), .imb_q(imb_q), .imb_g(imb_g),
    .flag_i(flag_i), .flag_q(flag_q), .flag_g(flag_g),
    .res_bubbles(res_bubbles)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // mode 1: rotate through all sectors; mode 0: cnt_a of sec_a, nbub bubbles, rest sec_b
  typedef struct packed {
    int mode; int sec_a; int cnt_a; int nbub; int sec_b; int thr; int gap;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{1, 0,   0,   0,  0,   0, 0},
    '{0, 2, 256,   0,  0, 100, 0},
    '{0, 9, 200,   0, 14, 200, 3},
    '{0, 5, 100, 100, 12,  50, 0},
    '{0, 0, 130,   0,  8,   4, 0},
    '{0, 0, 130,   0,  8,   3, 5},
    '{0, 15,  1, 255,  0,   0, 0}
  };

  // Sign word from angular distance between sector and projection rotation (R1).
  function automatic logic [7:0] word_of(int k);
    logic [7:0] w;
    for (int j = 0; j < 8; j++) w[j] = (((k - j + 16) % 16) < 8);
    return w;
  endfunction

  // Placement from the sector centre, in units of 11.25 degrees.
  function automatic int sgn_right(int k);
    int c; c = 2 * k + 1;
    return ((c < 8) || (c > 24)) ? 1 : -1;
  endfunction
  function automatic int sgn_top(int k);
    return ((2 * k + 1) < 16) ? 1 : -1;
  endfunction
  function automatic int sgn_diag(int k);
    int c; c = 2 * k + 1;
    return ((c < 8) || ((c > 16) && (c < 24))) ? 1 : -1;
  endfunction
  function automatic int absi(int v);
    return (v < 0) ? -v : v;
  endfunction

  int thr_nx = 0;
  int sel_nx = 8;
  bit pend = 0;
  int pi, pq, pg, pb, pt;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_res();
    chk("R6", "res_valid", int'(res_valid), 1);
    chk("R3", "imb_i", int'(imb_i), pi);
    chk("R4", "imb_q", int'(imb_q), pq);
    chk("R5", "imb_g", int'(imb_g), pg);
    chk("R2", "res_bubbles", int'(res_bubbles), pb);
    chk("R10", "flag_i", int'(flag_i), int'(absi(pi) > pt));
    chk("R10", "flag_q", int'(flag_q), int'(absi(pq) > pt));
    chk("R10", "flag_g", int'(flag_g), int'(absi(pg) > pt));
  endtask

  task automatic step_cyc(input logic v, input logic [7:0] w, input logic c);
    @(negedge clk);
    if (pend) begin
      check_res();
      pend = 0;
    end else if (res_valid) begin
      nchk++; nfail++;
      $display("FAIL R6 unexpected res_valid actual=1 expected=0");
    end
    thr = 17'(thr_nx);
    win_sel = 5'(sel_nx);
    in_valid = v; in_word = w; clr = c;
  endtask

  task automatic run_window(input vec_t v, input int len, input int chg_at, input int chg_sel);
    int ei, eq, eg, eb, k;
    bit isbub;
    ei = 0; eq = 0; eg = 0; eb = 0;
    thr_nx = v.thr;
    for (int n = 0; n < len; n++) begin
      if ((v.gap > 0) && ((n % v.gap) == v.gap - 1))
        step_cyc(1'b0, 8'h05, 1'b0);   // R12: idle cycle carries a bubble pattern
      isbub = 0; k = 0;
      if (v.mode == 1) k = n % 16;
      else if (n < v.cnt_a) k = v.sec_a;
      else if (n < v.cnt_a + v.nbub) isbub = 1;
      else k = v.sec_b;
      if (n == chg_at) sel_nx = chg_sel;
      if (isbub) begin
        eb++;
        step_cyc(1'b1, 8'h05, 1'b0);
      end else begin
        ei += sgn_right(k); eq += sgn_top(k); eg += sgn_diag(k);
        step_cyc(1'b1, word_of(k), 1'b0);
      end
    end
    pi = ei; pq = eq; pg = eg; pb = eb; pt = v.thr;
    pend = 1;
  endtask

  initial begin
    vec_t d;
    // R11: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "res_valid", int'(res_valid), 0);
    chk("R11", "imb_i", int'(imb_i), 0);
    chk("R11", "imb_q", int'(imb_q), 0);
    chk("R11", "imb_g", int'(imb_g), 0);
    chk("R11", "res_bubbles", int'(res_bubbles), 0);
    chk("R11", "flags", int'({flag_i, flag_q, flag_g}), 0);

    // start a window of 256 with a clear
    sel_nx = 8;
    step_cyc(1'b0, 8'h00, 1'b1);

    // table: windows back to back with no idle between them (R7)
    for (int t = 0; t < NV; t++) run_window(TBL[t], 256, -1, 0);

    // R8: change to 512 partway through; current window must stay 256
    d = '{0, 6, 256, 0, 0, 0, 0};
    run_window(d, 256, 10, 9);
    d = '{0, 10, 512, 0, 0, 0, 0};
    run_window(d, 512, -1, 0);

    // R9: partial window then clear (sample on the clear edge dropped);
    // win_sel 3 is clamped up to 8 (R6)
    sel_nx = 8; thr_nx = 0;
    for (int n = 0; n < 100; n++) step_cyc(1'b1, word_of(4), 1'b0);
    sel_nx = 3;
    step_cyc(1'b1, word_of(4), 1'b1);
    d = '{0, 13, 256, 0, 0, 0, 0};
    run_window(d, 256, -1, 0);

    // R6: win_sel 31 clamps to 2^16; full scale must not wrap
    sel_nx = 31;
    step_cyc(1'b0, 8'h00, 1'b1);
    d = '{0, 1, 65536, 0, 0, 65535, 0};
    run_window(d, 65536, -1, 0);
    step_cyc(1'b0, 8'h00, 1'b0);
    step_cyc(1'b0, 8'h00, 1'b0);
    step_cyc(1'b0, 8'h00, 1'b0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule